// File: doc/BRIEF.md
# Wrapping Burst Address Generator

This block sits between an on-chip bus slave and the sequencer that drives an external 16-bit memory bus. It takes one internal burst request and turns it into Word16 beat addresses. The request carries a start address, a count of 32-bit beats (1 to 16) and an internal wrap flag. Every 32-bit beat becomes two Word16 beats. The resulting address stream is then cut into external bursts of 4, 8 or 16 beats. Each beat is marked as the first and/or the last beat of its external burst, so the sequencer knows where to open and close device accesses.

The external bursts are either linear or wrapping. Linear bursts break at every length-aligned address and at every jump in the address stream. In wrapping mode the burst stays inside a window aligned to the external length. A burst may start anywhere in its window and wraps back to the window base. Page-mode reads are only legal on a bus that carries address and data on separate pins. If page mode is selected on a multiplexed bus, the block falls back to single-beat accesses.

The sequencer paces the stream with a ready signal. Configuration inputs are sampled together with the request. A new request is taken only once the previous burst has fully drained.

Top module: `wbag_top`

## Requirements
- R1: After a synchronous reset, `beat_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge, `req_ready` stays 0 until the edge that completes the final beat handshake, and requests offered while it is 0 are ignored. The burst has 2*(`req_beats`+1) Word16 beats. Bit 0 of `req_addr` is treated as 0.
- R3: Each 32-bit beat produces two Word16 beats, the even (low-half) address first and the odd address next.
- R4: With `req_wrap`=0, beat i (counting from 0) carries address A+i, where A is the even start address.
- R5: With `req_wrap`=1 and a Word16 count N of 2, 4, 8, 16 or 32, beat i carries base+((A-base+i) mod N), where base is A rounded down to a multiple of N. For any other count, `req_wrap` is ignored and the order is linear.
- R6: `cfg_len` selects the external length L: code 0 gives 4, code 1 gives 8, and codes 2 and 3 give 16.
- R7: With `cfg_ext_wrap`=0, a beat is marked first if it is beat 0, if its address is a multiple of L, or if its address is not the previous address plus one. A beat is marked last if it is the final beat or the next beat is marked first.
- R8: With `cfg_ext_wrap`=1, external burst j starts at the address s of stream beat j*L. Its k-th beat carries (s rounded down to a multiple of L)+((s+k) mod L). The burst is min(L, N-j*L) beats long, first on k=0 and last on its final beat.
- R9: A beat advances only on a cycle with `beat_ready`=1. While it is stalled, `beat_addr`, `beat_first` and `beat_last` hold their values.
- R10: If `cfg_page_rd`=1 and `cfg_muxed`=1, every beat is both first and last and carries the R4/R5 address. If `cfg_page_rd`=1 and `cfg_muxed`=0, R7/R8 apply unchanged.
- R11: `cfg_len`, `cfg_ext_wrap`, `cfg_page_rd` and `cfg_muxed` are sampled only when a request is taken. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Generator idle, request can be taken |
| req_addr | input | ADDR_W | Word16 start address (bit 0 ignored) |
| req_beats | input | 4 | Number of 32-bit beats minus one |
| req_wrap | input | 1 | Internal burst wraps |
| cfg_len | input | 2 | External burst length code |
| cfg_ext_wrap | input | 1 | External bursts wrap within their window |
| cfg_page_rd | input | 1 | Page-mode read selected |
| cfg_muxed | input | 1 | External bus multiplexes address and data |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Sequencer takes the beat |
| beat_addr | output | ADDR_W | Word16 address of the beat |
| beat_first | output | 1 | First beat of an external burst |
| beat_last | output | 1 | Last beat of an external burst |

## Verification
The assertions assume that the sequencer raises `beat_ready` only to take a beat that is already valid. They also assume that a request's address range does not run past the top of the address space, because the generator lets addresses roll over silently. Every directed case in the bench picks a start address well below that limit. The stall pattern pulls ready low only while a burst is in flight, so each hold check compares values from one burst.

// File: rtl/wbag_pkg.sv
package wbag_pkg;

    typedef enum logic [1:0] {
        EXT_LEN4      = 2'd0,
        EXT_LEN8      = 2'd1,
        EXT_LEN16     = 2'd2,
        EXT_LEN16_ALT = 2'd3
    } ext_len_e;

    // Per-burst mode captured at request acceptance
    typedef struct packed {
        logic       ext_wrap;
        logic       single_beat;
        logic [2:0] len_lg;
    } beat_mode_t;

    // Address taps evaluated by the beat generator
    localparam int TAP_PREV = 0;
    localparam int TAP_CUR  = 1;
    localparam int TAP_NEXT = 2;
    localparam int TAP_WIN  = 3;
    localparam int NUM_TAPS = 4;

    function automatic logic [2:0] len_log2(ext_len_e code);
        case (code)
            EXT_LEN4: return 3'd2;
            EXT_LEN8: return 3'd3;
            default:  return 3'd4;
        endcase
    endfunction

    function automatic logic is_pow2(logic [7:0] v);
        return (v != 8'd0) && ((v & (v - 8'd1)) == 8'd0);
    endfunction

endpackage

// File: rtl/wbag_seq_map.sv
// Maps a linear beat index onto the internal burst order (linear or wrapped).
module wbag_seq_map #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] wrap_mask,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] lin;

    always_comb begin
        lin  = start_addr + ADDR_W'(index);
        addr = (start_addr & ~wrap_mask) | (lin & wrap_mask);
    end
endmodule

// File: rtl/wbag_ctrl.sv
// Request capture, burst context and beat index.
module wbag_ctrl
    import wbag_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BEAT_W = 4,
    parameter int IDX_W  = BEAT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              req_wrap,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_ext_wrap,
    input  logic              cfg_page_rd,
    input  logic              cfg_muxed,
    input  logic              beat_fire,
    output logic              busy,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] wrap_mask,
    output logic [IDX_W-1:0]  last_idx,
    output beat_mode_t        mode,
    output logic [IDX_W-1:0]  idx
);
    logic              accept;
    logic [BEAT_W:0]   nbeats32;
    logic [IDX_W-1:0]  last_idx_d;
    logic              wrap_ok;
    logic              single_d;
    beat_mode_t        mode_d;

    always_comb begin
        accept     = req_valid && !busy;
        nbeats32   = {1'b0, req_beats} + {{BEAT_W{1'b0}}, 1'b1};
        last_idx_d = IDX_W'({req_beats, 1'b1});
        wrap_ok    = req_wrap && is_pow2(8'(nbeats32));
        single_d   = cfg_page_rd && cfg_muxed;
        mode_d.single_beat = single_d;
        mode_d.ext_wrap    = cfg_ext_wrap && !single_d;
        mode_d.len_lg      = len_log2(ext_len_e'(cfg_len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            idx        <= '0;
            start_addr <= '0;
            wrap_mask  <= '0;
            last_idx   <= '0;
            mode       <= '0;
        end else if (accept) begin
            busy       <= 1'b1;
            idx        <= '0;
            start_addr <= req_addr & ~ADDR_W'(1);
            wrap_mask  <= wrap_ok ? ADDR_W'(last_idx_d) : {ADDR_W{1'b1}};
            last_idx   <= last_idx_d;
            mode       <= mode_d;
        end else if (busy && beat_fire) begin
            if (idx == last_idx) begin
                busy <= 1'b0;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= last_idx));

    assert_ctx_held_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(start_addr) && $stable(mode) && $stable(last_idx)
                  && $stable(wrap_mask)));

endmodule

// File: rtl/wbag_beat_gen.sv
// Address and first/last marking for the current beat.
module wbag_beat_gen
    import wbag_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] wrap_mask,
    input  logic [IDX_W-1:0]  last_idx,
    input  beat_mode_t        mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              first,
    output logic              last
);
    logic [ADDR_W-1:0] lmask;
    logic [IDX_W-1:0]  lmask_i;
    logic [IDX_W-1:0]  k;
    logic [IDX_W-1:0]  taps     [NUM_TAPS];
    logic [ADDR_W-1:0] tap_addr [NUM_TAPS];

    always_comb begin
        lmask          = (ADDR_W'(1) << mode.len_lg) - ADDR_W'(1);
        lmask_i        = IDX_W'(lmask);
        k              = idx & lmask_i;
        taps[TAP_PREV] = idx - IDX_W'(1);
        taps[TAP_CUR]  = idx;
        taps[TAP_NEXT] = idx + IDX_W'(1);
        taps[TAP_WIN]  = idx & ~lmask_i;
    end

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        wbag_seq_map #(
            .ADDR_W(ADDR_W),
            .IDX_W (IDX_W)
        ) u_map (
            .start_addr(start_addr),
            .wrap_mask (wrap_mask),
            .index     (taps[t]),
            .addr      (tap_addr[t])
        );
    end

    always_comb begin
        logic [ADDR_W-1:0] a_prev, a_cur, a_next, a_win;
        a_prev = tap_addr[TAP_PREV];
        a_cur  = tap_addr[TAP_CUR];
        a_next = tap_addr[TAP_NEXT];
        a_win  = tap_addr[TAP_WIN];
        if (mode.single_beat) begin
            addr  = a_cur;
            first = 1'b1;
            last  = 1'b1;
        end else if (mode.ext_wrap) begin
            addr  = (a_win & ~lmask) | ((a_win + ADDR_W'(k)) & lmask);
            first = (k == '0);
            last  = (k == lmask_i) || (idx == last_idx);
        end else begin
            addr  = a_cur;
            first = (idx == '0) || ((a_cur & lmask) == '0)
                    || (a_cur != a_prev + ADDR_W'(1));
            last  = (idx == last_idx) || ((a_next & lmask) == '0)
                    || (a_next != a_cur + ADDR_W'(1));
        end
    end
endmodule

// File: rtl/wbag_top.sv
module wbag_top
    import wbag_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int MAX_IBEATS  = 16,
    localparam int BEAT_W     = $clog2(MAX_IBEATS),
    localparam int IDX_W      = BEAT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              req_wrap,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_ext_wrap,
    input  logic              cfg_page_rd,
    input  logic              cfg_muxed,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_first,
    output logic              beat_last
);
    logic              busy;
    logic              beat_fire;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] wrap_mask;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  idx;
    beat_mode_t        mode;
    logic [ADDR_W-1:0] win_mask;

    assign beat_valid = busy;
    assign req_ready  = !busy;
    assign beat_fire  = busy && beat_ready;
    assign win_mask   = (ADDR_W'(1) << mode.len_lg) - ADDR_W'(1);

    wbag_ctrl #(
        .ADDR_W(ADDR_W),
        .BEAT_W(BEAT_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_beats   (req_beats),
        .req_wrap    (req_wrap),
        .cfg_len     (cfg_len),
        .cfg_ext_wrap(cfg_ext_wrap),
        .cfg_page_rd (cfg_page_rd),
        .cfg_muxed   (cfg_muxed),
        .beat_fire   (beat_fire),
        .busy        (busy),
        .start_addr  (start_addr),
        .wrap_mask   (wrap_mask),
        .last_idx    (last_idx),
        .mode        (mode),
        .idx         (idx)
    );

    wbag_beat_gen #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_gen (
        .start_addr(start_addr),
        .wrap_mask (wrap_mask),
        .last_idx  (last_idx),
        .mode      (mode),
        .idx       (idx),
        .addr      (beat_addr),
        .first     (beat_first),
        .last      (beat_last)
    );

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)
            && $stable(beat_first) && $stable(beat_last)));

    assert_take_opens_burst_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (beat_valid && beat_first));

    assert_last_then_first_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && beat_last) |=> (!beat_valid || beat_first));

    assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last && !mode.ext_wrap)
            |=> (!beat_first && beat_addr == $past(beat_addr) + ADDR_W'(1)));

    assert_wrap_window_R8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last && mode.ext_wrap)
            |=> (!beat_first && ((beat_addr & ~win_mask) == ($past(beat_addr) & ~win_mask))));

endmodule

// File: tb/tb_wbag_top.sv
`timescale 1ns/1ps
module tb_wbag_top;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [3:0]        req_beats;
    logic              req_wrap;
    logic [1:0]        cfg_len;
    logic              cfg_ext_wrap;
    logic              cfg_page_rd;
    logic              cfg_muxed;
    logic              beat_valid;
    logic              beat_ready;
    logic [ADDR_W-1:0] beat_addr;
    logic              beat_first;
    logic              beat_last;

    always #2.5 clk = ~clk;

    wbag_top #(.ADDR_W(ADDR_W), .MAX_IBEATS(16)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_beats(req_beats), .req_wrap(req_wrap),
        .cfg_len(cfg_len), .cfg_ext_wrap(cfg_ext_wrap), .cfg_page_rd(cfg_page_rd),
        .cfg_muxed(cfg_muxed), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_first(beat_first), .beat_last(beat_last)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int ea [32];
    bit ef [32];
    bit el [32];

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int fseq(int a, int n, bit iw, int i);
        bit p = (n == 2) || (n == 4) || (n == 8) || (n == 16) || (n == 32);
        if (iw && p) begin
            int b = a - (a % n);
            return b + ((a - b + i) % n);
        end
        return a + i;
    endfunction

    task automatic build_expect(int a0, int beats, bit iw, int lcode, bit ew, bit page, bit mux);
        int a = a0 & ~1;
        int n = 2 * (beats + 1);
        int l = (lcode == 0) ? 4 : (lcode == 1) ? 8 : 16;
        if (page && mux) begin
            for (int i = 0; i < n; i++) begin
                ea[i] = fseq(a, n, iw, i); ef[i] = 1; el[i] = 1;
            end
        end else if (ew) begin
            for (int j = 0; j * l < n; j++) begin
                int s = fseq(a, n, iw, j * l);
                int len = (n - j * l < l) ? n - j * l : l;
                for (int k = 0; k < len; k++) begin
                    ea[j * l + k] = s - (s % l) + (((s % l) + k) % l);
                    ef[j * l + k] = (k == 0);
                    el[j * l + k] = (k == len - 1);
                end
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                int c = fseq(a, n, iw, i);
                ea[i] = c;
                ef[i] = (i == 0) || (c % l == 0) || (c != fseq(a, n, iw, i - 1) + 1);
            end
            for (int i = 0; i < n; i++) begin
                el[i] = (i == n - 1) || ef[i + 1];
            end
        end
    endtask

    task automatic run(string rq, int a, int beats, bit iw, int lcode, bit ew,
                       bit page, bit mux, bit stall, bit disturb);
        int n = 2 * (beats + 1);
        int idx = 0;
        int cyc = 0;
        bit held = 0;
        int held_addr = 0;
        bit hf = 0;
        bit hl = 0;
        @(negedge clk);
        build_expect(a, beats, iw, lcode, ew, page, mux);
        req_addr = ADDR_W'(a); req_beats = 4'(beats); req_wrap = iw;
        cfg_len = 2'(lcode); cfg_ext_wrap = ew; cfg_page_rd = page; cfg_muxed = mux;
        req_valid = 1'b1; beat_ready = 1'b0;
        @(negedge clk);
        req_valid = disturb;
        if (disturb) begin
            req_addr = 'hABC; req_wrap = 1'b1; cfg_len = 2'd2; cfg_ext_wrap = 1'b1;
            cfg_page_rd = 1'b1; cfg_muxed = 1'b1;
        end
        while (idx < n && cyc < 500) begin
            beat_ready = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (disturb) chk(req_ready == 1'b0, "R2", "req_ready while busy", int'(req_ready), 0);
            if (held) begin
                chk(beat_valid && int'(beat_addr) == held_addr && beat_first == hf
                    && beat_last == hl, "R9", "hold under stall", int'(beat_addr), held_addr);
                held = 0;
            end
            if (beat_valid && beat_ready) begin
                chk(int'(beat_addr) == ea[idx], rq, $sformatf("addr beat %0d", idx),
                    int'(beat_addr), ea[idx]);
                chk(beat_first == ef[idx], rq, $sformatf("first beat %0d", idx),
                    int'(beat_first), int'(ef[idx]));
                chk(beat_last == el[idx], rq, $sformatf("last beat %0d", idx),
                    int'(beat_last), int'(el[idx]));
                if (idx == n - 1) req_valid = 1'b0;
                idx++;
            end else if (beat_valid) begin
                held = 1; held_addr = int'(beat_addr); hf = beat_first; hl = beat_last;
            end
            cyc++;
            @(negedge clk);
        end
        beat_ready = 1'b0;
        #1;
        chk(idx == n, rq, "beat count", idx, n);
        chk(req_ready == 1'b1 && beat_valid == 1'b0, "R2", "idle after burst",
            int'({req_ready, beat_valid}), 2);
    endtask

    task automatic t_reset;
        rst = 1'b1; req_valid = 1'b0; beat_ready = 1'b0; req_addr = '0; req_beats = '0;
        req_wrap = 1'b0; cfg_len = '0; cfg_ext_wrap = 1'b0; cfg_page_rd = 1'b0; cfg_muxed = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(beat_valid == 1'b0, "R1", "beat_valid after reset", int'(beat_valid), 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    endtask

    // Linear stream, two 4-beat external bursts, low half first
    task automatic t_linear;      run("R3,R4", 'h100, 3, 0, 0, 0, 0, 0, 0, 0); endtask
    // Misaligned start splits at the 8-word boundary
    task automatic t_unaligned;   run("R7", 'h106, 4, 0, 1, 0, 0, 0, 0, 0); endtask
    // Internal wrap over 16 words, 4-beat linear bursts
    task automatic t_int_wrap;    run("R5", 'h10C, 7, 1, 0, 0, 0, 0, 0, 0); endtask
    // Internal wrap smaller than external length: split at the jump
    task automatic t_int_wrap_sm; run("R5,R7", 'h206, 1, 1, 2, 0, 0, 0, 0, 0); endtask
    // Non power-of-two count ignores internal wrap
    task automatic t_int_nonpow2; run("R5", 'h20A, 2, 1, 2, 0, 0, 0, 0, 0); endtask
    // External wrapping bursts of 8
    task automatic t_ext_wrap;    run("R8", 'h306, 7, 0, 1, 1, 0, 0, 0, 0); endtask
    // Burst shorter than the window still wraps inside it
    task automatic t_ext_short;   run("R8", 'h416, 1, 0, 1, 1, 0, 0, 0, 0); endtask
    // Internal wrap of 32 words feeding wrapped external bursts
    task automatic t_both_wrap;   run("R5,R8", 'h1A4, 15, 1, 1, 1, 0, 0, 0, 0); endtask
    // Length code 3 behaves as 16
    task automatic t_len_alt;     run("R6", 'h50C, 7, 0, 3, 0, 0, 0, 0, 0); endtask
    // Page read on a multiplexed bus degrades to single beats; not on a plain bus
    task automatic t_page;
        run("R10", 'h600, 3, 0, 0, 0, 1, 1, 0, 0);
        run("R10", 'h640, 3, 0, 0, 0, 1, 0, 0, 0);
    endtask
    // Back-pressure pattern during wrapped bursts
    task automatic t_stall;       run("R9", 'h700, 5, 0, 1, 1, 0, 0, 1, 0); endtask
    // Config and request changes during a burst are ignored
    task automatic t_disturb;     run("R11,R2", 'h800, 3, 0, 0, 0, 0, 0, 1, 1); endtask
    // Odd start address is treated as even
    task automatic t_odd_addr;    run("R2", 'h901, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        t_reset();
        t_linear();
        t_unaligned();
        t_int_wrap();
        t_int_wrap_sm();
        t_int_nonpow2();
        t_ext_wrap();
        t_ext_short();
        t_both_wrap();
        t_len_alt();
        t_page();
        t_stall();
        t_disturb();
        t_odd_addr();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule